// File: doc/BRIEF.md
# Asynchronous Flash Bus Front-End

This block sits behind the pins of an asynchronous flash device and turns the three active-low strobes (chip select, output select and write select), together with the address and data lines, into clean events in the fast on-chip clock domain. It oversamples every pin through a short synchronizer and captures write cycles as single-cycle strobes with the captured address and data. It also decides what a read cycle returns, and drives the data-enable pins for the low and high bytes.

A read returns one of three things. A bus read normally returns the word that the array side supplies. In identification mode it returns a manufacturer or device code instead. Identification mode is entered either by a high-voltage indication on address line 9 or by a mode flag from the command logic. A protection-verify read returns the protection state of the block that the upper address bits select.

The block flags standby whenever it is deselected and the controller is idle. It raises a low-power flag after a programmable number of clock cycles with no change on the address or control pins. The flag has no effect on the outputs.

Top module: `flash_bus_front`

## Requirements
- R1: A read drives the low data byte (`dq_oe_lo` = 1) exactly when the synchronized `ce_n` and `oe_n` are both low. It takes effect 3 clock edges after the pins change.
- R2: With `oe_n` high, or with `ce_n` high, neither data byte is driven (`dq_oe_lo` = `dq_oe_hi` = 0). This holds whatever the state of `we_n`.
- R3: `standby` is 1 exactly when `ce_n` is high and `ctrl_busy` is 0. While `standby` is 1, no data byte is driven.
- R4: A write cycle is `ce_n` low, `we_n` low and `oe_n` high. The address is captured at the start of the cycle, which is the later falling edge of `ce_n` or `we_n`. Address changes after that point are ignored.
- R5: The data is captured at the end of the write cycle, which is the earlier rising edge of `ce_n` or `we_n`. `wr_strobe` pulses for exactly one cycle per write cycle, and `wr_addr` and `wr_data` change only with that pulse. With `oe_n` low, no write cycle occurs.
- R6: Identification mode is active when `hv_a9` = 1 with address bit 1 = 0, or when `sig_mode` = 1 with `hv_a9` = 0. In this mode, address bit 0 = 0 returns 8'h20 on the low byte and address bit 0 = 1 returns the parameter `DEV_CODE`. All other address bits are ignored.
- R7: In word mode (`word_mode` = 1), identification and protection reads drive the high byte as 8'h00. In byte mode (`word_mode` = 0), the high byte is never driven.
- R8: With `hv_a9` = 1 and address bits 0 = 0, 1 = 1 and 6 = 0, a read returns 8'h01 if `prot_map[addr[16:12]]` is set, and 8'h00 otherwise.
- R9: Any other read returns `array_data`. In word mode it returns both bytes; in byte mode it returns only `array_data[7:0]`.
- R10: `low_power` rises after `IDLE_CYCLES` cycles with no change on the synchronized address or control pins. It clears on the next change and does not alter the data enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output select, active low |
| we_n | input | 1 | Write select, active low |
| addr | input | ADDR_W | Address pins |
| dq_in | input | 16 | Data pins as seen on input |
| hv_a9 | input | 1 | High voltage detected on address line 9 |
| sig_mode | input | 1 | Identification mode entered by command |
| word_mode | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| ctrl_busy | input | 1 | Program/erase controller busy |
| prot_map | input | 2**BLK_BITS | Per-block protection bits |
| array_data | input | 16 | Array word for the current address |
| dq_out | output | 16 | Data to drive on the pins |
| dq_oe_lo | output | 1 | Drive enable, low byte |
| dq_oe_hi | output | 1 | Drive enable, high byte |
| standby | output | 1 | Deselected and idle |
| low_power | output | 1 | Bus inactivity flag |
| wr_strobe | output | 1 | One-cycle pulse at the end of a write cycle |
| wr_addr | output | ADDR_W | Address captured for the write |
| wr_data | output | 16 | Data captured for the write |

## Verification
The bench goes after the two write-edge orderings: select before write-enable, and write-enable before select. It moves the address after the cycle starts and the data after the first release. A design that captured at the wrong edge would report a stale or late address or data word, and one that retriggered would count extra strobes. It sweeps the low address bits and scrambled upper bits in both identification entries and both widths, and walks all 32 protection blocks against a map and its inverse. These sweeps catch a wrong priority between protection verify, identification and array data, and an upper byte driven in byte mode. It also measures the inactivity window on both sides of its limit, which catches a flag that fires early, never clears, or turns the data enables off.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;

    localparam int DATA_W = 16;
    localparam int HALF_W = DATA_W / 2;

    localparam logic [HALF_W-1:0] MFR_ID    = 8'h20;
    localparam logic [HALF_W-1:0] PROT_SET  = 8'h01;
    localparam logic [HALF_W-1:0] PROT_CLR  = 8'h00;
    localparam logic [HALF_W-1:0] UPPER_ZERO = 8'h00;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
    } bus_ctl_t;

    typedef enum logic [1:0] {
        SRC_ARRAY = 2'd0,
        SRC_IDENT = 2'd1,
        SRC_PROT  = 2'd2
    } rd_src_e;

    typedef struct packed {
        logic              drv_lo;
        logic              drv_hi;
        logic [DATA_W-1:0] word;
    } rd_drive_t;

    // Priority: protection verify, then identification, then array.
    function automatic rd_src_e pick_src(input logic hv, input logic cmd,
                                         input logic a0, input logic a1,
                                         input logic a6);
        if (hv && a1 && !a0 && !a6)
            return SRC_PROT;
        if ((hv && !a1) || (cmd && !hv))
            return SRC_IDENT;
        return SRC_ARRAY;
    endfunction

    function automatic logic is_write(input bus_ctl_t c);
        return !c.ce_n && !c.we_n && c.oe_n;
    endfunction

    function automatic logic is_read(input bus_ctl_t c);
        return !c.ce_n && !c.oe_n;
    endfunction

endpackage

// File: rtl/flash_fe_sync.sv
module flash_fe_sync #(
    parameter int              WIDTH   = 8,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) stage_q[0] <= RST_VAL;
                else     stage_q[0] <= d_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stage_q <= {STAGES{RST_VAL}};
                else     stage_q <= {stage_q[STAGES-2:0], d_in};
            end
        end
    endgenerate

    assign d_out = stage_q[LAST];
endmodule

// File: rtl/flash_fe_wcap.sv
module flash_fe_wcap
    import flash_fe_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ctl_t          ctl,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] dq_s,
    output logic              wr_strobe,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    logic              cyc_now;
    logic              cyc_d;
    logic              cyc_start;
    logic              cyc_end;
    logic [ADDR_W-1:0] addr_hold;
    logic [DATA_W-1:0] data_hold;

    assign cyc_now   = is_write(ctl);
    assign cyc_start = cyc_now && !cyc_d;   // later of the two falls
    assign cyc_end   = cyc_d && !cyc_now;   // earlier of the two rises

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_d     <= 1'b0;
            addr_hold <= '0;
            data_hold <= '0;
            wr_strobe <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
        end else begin
            cyc_d     <= cyc_now;
            wr_strobe <= cyc_end;
            if (cyc_start) addr_hold <= addr_s;
            if (cyc_now)   data_hold <= dq_s;
            if (cyc_end) begin
                wr_addr <= addr_hold;
                wr_data <= data_hold;
            end
        end
    end

    // R5: a strobe never lasts longer than one cycle
    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |=> !wr_strobe);

    // R5: captured write fields move only together with the strobe
    assert_fields_with_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(wr_addr) || !$stable(wr_data) |-> wr_strobe);

    // R4: the held address cannot move in the middle of a write cycle
    assert_addr_frozen_R4: assert property (@(posedge clk) disable iff (rst)
        cyc_d && cyc_now |=> $stable(addr_hold));
endmodule

// File: rtl/flash_fe_rdmux.sv
module flash_fe_rdmux
    import flash_fe_pkg::*;
#(
    parameter logic [HALF_W-1:0] DEV_CODE = 8'hD3,
    parameter int                BLK_BITS = 5,
    localparam int               NUM_BLK  = 1 << BLK_BITS
) (
    input  logic                clk,
    input  logic                rst,
    input  bus_ctl_t            ctl,
    input  logic                a0,
    input  logic                a1,
    input  logic                a6,
    input  logic [BLK_BITS-1:0] blk,
    input  logic                hv_s,
    input  logic                sig_mode,
    input  logic                word_mode,
    input  logic                ctrl_busy,
    input  logic [NUM_BLK-1:0]  prot_map,
    input  logic [DATA_W-1:0]   array_data,
    output logic [DATA_W-1:0]   dq_out,
    output logic                dq_oe_lo,
    output logic                dq_oe_hi,
    output logic                standby
);
    rd_src_e   src;
    rd_drive_t nxt;
    logic      rd_now;
    logic      idle_desel;

    assign rd_now     = is_read(ctl);
    assign idle_desel = ctl.ce_n && !ctrl_busy;
    assign src        = pick_src(hv_s, sig_mode, a0, a1, a6);

    always_comb begin
        nxt        = '0;
        nxt.drv_lo = rd_now;
        nxt.drv_hi = rd_now && word_mode;
        if (rd_now) begin
            unique case (src)
                SRC_PROT: begin
                    nxt.word[HALF_W-1:0]      = prot_map[blk] ? PROT_SET : PROT_CLR;
                    nxt.word[DATA_W-1:HALF_W] = UPPER_ZERO;
                end
                SRC_IDENT: begin
                    nxt.word[HALF_W-1:0]      = a0 ? DEV_CODE : MFR_ID;
                    nxt.word[DATA_W-1:HALF_W] = UPPER_ZERO;
                end
                default: begin
                    nxt.word[HALF_W-1:0]      = array_data[HALF_W-1:0];
                    nxt.word[DATA_W-1:HALF_W] = word_mode ?
                                                array_data[DATA_W-1:HALF_W] : UPPER_ZERO;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dq_out   <= '0;
            dq_oe_lo <= 1'b0;
            dq_oe_hi <= 1'b0;
            standby  <= 1'b0;
        end else begin
            dq_out   <= nxt.word;
            dq_oe_lo <= nxt.drv_lo;
            dq_oe_hi <= nxt.drv_hi;
            standby  <= idle_desel;
        end
    end

    // R3: standby keeps both bytes off the bus
    assert_standby_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        standby |-> !dq_oe_lo && !dq_oe_hi);

    // R7: the high byte is never driven on its own
    assert_hi_needs_lo_R7: assert property (@(posedge clk) disable iff (rst)
        dq_oe_hi |-> dq_oe_lo);

    // R1: driving follows a select seen one edge earlier
    assert_drive_needs_select_R1: assert property (@(posedge clk) disable iff (rst)
        dq_oe_lo |-> $past(!ctl.ce_n && !ctl.oe_n));

    // R2: output select released means no drive next cycle
    assert_released_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        ctl.oe_n |=> !dq_oe_lo && !dq_oe_hi);
endmodule

// File: rtl/flash_fe_idle.sv
module flash_fe_idle #(
    parameter int              WIDTH       = 20,
    parameter int              IDLE_CYCLES = 15,
    parameter logic [WIDTH-1:0] RST_VAL    = '0,
    localparam int             CNT_W       = $clog2(IDLE_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] watch,
    output logic             low_power
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IDLE_CYCLES);

    logic [WIDTH-1:0] prev_q;
    logic [CNT_W-1:0] quiet_cnt;
    logic             activity;

    assign activity  = (watch != prev_q);
    assign low_power = (quiet_cnt == LIMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q    <= RST_VAL;
            quiet_cnt <= '0;
        end else begin
            prev_q <= watch;
            if (activity)
                quiet_cnt <= '0;
            else if (quiet_cnt != LIMIT)
                quiet_cnt <= quiet_cnt + 1'b1;
        end
    end

    // R10: any pin movement clears the flag on the following cycle
    assert_activity_clears_R10: assert property (@(posedge clk) disable iff (rst)
        activity |=> !low_power);

    // R10: once raised, the flag stays up while the pins are quiet
    assert_flag_holds_R10: assert property (@(posedge clk) disable iff (rst)
        low_power && !activity |=> low_power);
endmodule

// File: rtl/flash_bus_front.sv
module flash_bus_front
    import flash_fe_pkg::*;
#(
    parameter int                ADDR_W      = 17,
    parameter int                BLK_LSB     = 12,
    parameter int                BLK_BITS    = 5,
    parameter int                SYNC_STAGES = 2,
    parameter int                IDLE_CYCLES = 15,
    parameter logic [HALF_W-1:0] DEV_CODE    = 8'hD3,
    localparam int               NUM_BLK     = 1 << BLK_BITS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ce_n,
    input  logic               oe_n,
    input  logic               we_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  dq_in,
    input  logic               hv_a9,
    input  logic               sig_mode,
    input  logic               word_mode,
    input  logic               ctrl_busy,
    input  logic [NUM_BLK-1:0] prot_map,
    input  logic [DATA_W-1:0]  array_data,
    output logic [DATA_W-1:0]  dq_out,
    output logic               dq_oe_lo,
    output logic               dq_oe_hi,
    output logic               standby,
    output logic               low_power,
    output logic               wr_strobe,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [DATA_W-1:0]  wr_data
);
    localparam int CTL_W   = $bits(bus_ctl_t);
    localparam int SYNC_W  = CTL_W + 1 + ADDR_W + DATA_W;
    localparam int WATCH_W = CTL_W + ADDR_W;
    localparam logic [SYNC_W-1:0]  SYNC_RST  = {{CTL_W{1'b1}}, {(SYNC_W-CTL_W){1'b0}}};
    localparam logic [WATCH_W-1:0] WATCH_RST = {{CTL_W{1'b1}}, {ADDR_W{1'b0}}};

    bus_ctl_t          ctl_raw;
    bus_ctl_t          ctl_s;
    logic [SYNC_W-1:0] pins_raw;
    logic [SYNC_W-1:0] pins_s;
    logic              hv_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] dq_s;

    assign ctl_raw  = '{ce_n: ce_n, oe_n: oe_n, we_n: we_n};
    assign pins_raw = {ctl_raw, hv_a9, addr, dq_in};

    flash_fe_sync #(
        .WIDTH   (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (pins_raw),
        .d_out (pins_s)
    );

    assign ctl_s  = bus_ctl_t'(pins_s[SYNC_W-1 -: CTL_W]);
    assign hv_s   = pins_s[SYNC_W-CTL_W-1];
    assign addr_s = pins_s[DATA_W +: ADDR_W];
    assign dq_s   = pins_s[DATA_W-1:0];

    flash_fe_wcap #(
        .ADDR_W (ADDR_W)
    ) u_wcap (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl_s),
        .addr_s    (addr_s),
        .dq_s      (dq_s),
        .wr_strobe (wr_strobe),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    flash_fe_rdmux #(
        .DEV_CODE (DEV_CODE),
        .BLK_BITS (BLK_BITS)
    ) u_rdmux (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl_s),
        .a0         (addr_s[0]),
        .a1         (addr_s[1]),
        .a6         (addr_s[6]),
        .blk        (addr_s[BLK_LSB +: BLK_BITS]),
        .hv_s       (hv_s),
        .sig_mode   (sig_mode),
        .word_mode  (word_mode),
        .ctrl_busy  (ctrl_busy),
        .prot_map   (prot_map),
        .array_data (array_data),
        .dq_out     (dq_out),
        .dq_oe_lo   (dq_oe_lo),
        .dq_oe_hi   (dq_oe_hi),
        .standby    (standby)
    );

    flash_fe_idle #(
        .WIDTH       (WATCH_W),
        .IDLE_CYCLES (IDLE_CYCLES),
        .RST_VAL     (WATCH_RST)
    ) u_idle (
        .clk       (clk),
        .rst       (rst),
        .watch     ({ctl_s, addr_s}),
        .low_power (low_power)
    );

    // R5: no write strobe can come out of a read cycle
    assert_no_write_on_read_R5: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |-> !dq_oe_lo);
endmodule

// File: tb/flash_bus_front_bench.sv
module flash_bus_front_bench;
    localparam logic [7:0] DEV = 8'hD4;
    localparam int IDLE = 15;

    logic        clk = 1'b0;
    logic        rst;
    logic        ce_n, oe_n, we_n;
    logic [16:0] addr;
    logic [15:0] dq_in;
    logic        hv_a9, sig_mode, word_mode, ctrl_busy;
    logic [31:0] prot_map;
    logic [15:0] array_data;
    logic [15:0] dq_out;
    logic        dq_oe_lo, dq_oe_hi, standby, low_power, wr_strobe;
    logic [16:0] wr_addr;
    logic [15:0] wr_data;

    int n_chk = 0;
    int n_fail = 0;
    int n_strobe = 0;
    bit done = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #5 clk = ~clk;

    assign array_data = addr[15:0] ^ 16'h5A3C;

    flash_bus_front #(.DEV_CODE(DEV), .IDLE_CYCLES(IDLE)) u_flash_bus_front (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .dq_in(dq_in), .hv_a9(hv_a9), .sig_mode(sig_mode),
        .word_mode(word_mode), .ctrl_busy(ctrl_busy), .prot_map(prot_map),
        .array_data(array_data), .dq_out(dq_out), .dq_oe_lo(dq_oe_lo),
        .dq_oe_hi(dq_oe_hi), .standby(standby), .low_power(low_power),
        .wr_strobe(wr_strobe), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always @(negedge clk) if (!rst && wr_strobe) n_strobe++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        return s * 32'd1103515245 + 32'd12345;
    endfunction

    // expected {drive_hi, word} for a read from the requirements
    function automatic logic [16:0] expect_rd(input logic hv, input logic cmd,
                                              input logic wd, input logic [16:0] a,
                                              input logic [31:0] pm);
        logic [7:0]  lo;
        logic [7:0]  hi;
        logic [15:0] arr;
        arr = a[15:0] ^ 16'h5A3C;
        if (hv && a[1] && !a[0] && !a[6]) begin
            lo = pm[a[16:12]] ? 8'h01 : 8'h00;        // R8
            hi = 8'h00;
        end else if (hv ? !a[1] : cmd) begin
            lo = a[0] ? DEV : 8'h20;                  // R6
            hi = 8'h00;
        end else begin
            lo = arr[7:0];                            // R9
            hi = wd ? arr[15:8] : 8'h00;
        end
        return {wd, hi, lo};
    endfunction

    task automatic do_read(input string tag, input logic hv, input logic cmd,
                           input logic wd, input logic [16:0] a);
        logic [16:0] e;
        hv_a9 = hv; sig_mode = cmd; word_mode = wd; addr = a;
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        wait_n(4);
        e = expect_rd(hv, cmd, wd, a, prot_map);
        chk({tag, " lo byte"}, {24'd0, dq_out[7:0]}, {24'd0, e[7:0]});
        chk({"R1 ", tag, " drive lo"}, {31'd0, dq_oe_lo}, 32'd1);
        chk({"R7 ", tag, " drive hi"}, {31'd0, dq_oe_hi}, {31'd0, e[16]});
        if (wd) chk({"R7 ", tag, " hi byte"}, {24'd0, dq_out[15:8]}, {24'd0, e[15:8]});
    endtask

    initial begin
        rst = 1'b1;
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        addr = '0; dq_in = '0; hv_a9 = 0; sig_mode = 0; word_mode = 1;
        ctrl_busy = 0; prot_map = 32'hA5C3_1E69;
        wait_n(3);
        rst = 1'b0;
        wait_n(4);

        // reset and deselected state
        chk("R3 standby after reset", {31'd0, standby}, 32'd1);
        chk("R2 no drive after reset", {30'd0, dq_oe_hi, dq_oe_lo}, 32'd0);
        chk("R5 no strobe after reset", n_strobe, 0);

        // R3: busy controller leaves standby off, still no drive
        ctrl_busy = 1; oe_n = 0; wait_n(4);
        chk("R3 busy not standby", {31'd0, standby}, 32'd0);
        chk("R2 ce high no drive", {30'd0, dq_oe_hi, dq_oe_lo}, 32'd0);
        ctrl_busy = 0; oe_n = 1; wait_n(4);

        // R2: selected but oe high
        ce_n = 0; wait_n(4);
        chk("R2 oe high no drive", {30'd0, dq_oe_hi, dq_oe_lo}, 32'd0);
        chk("R3 selected not standby", {31'd0, standby}, 32'd0);
        ce_n = 1; wait_n(4);

        // R4/R5: write enable falls first, select falls later, select... we rises first
        addr = 17'h0_1111; we_n = 0; wait_n(4);
        addr = 17'h0_2222; wait_n(4);
        ce_n = 0; wait_n(4);
        addr = 17'h0_3333; dq_in = 16'hBEEF; wait_n(4);
        we_n = 1; wait_n(4);
        dq_in = 16'h0000; ce_n = 1; wait_n(4);
        chk("R5 one strobe first write", n_strobe, 1);
        chk("R4 addr at later fall (ce)", {15'd0, wr_addr}, 32'h0_2222);
        chk("R5 data at first rise (we)", {16'd0, wr_data}, 32'h0000_BEEF);

        // select falls first, write enable later; select rises first
        addr = 17'h1_0A0A; ce_n = 0; wait_n(4);
        addr = 17'h1_0B0B; wait_n(4);
        we_n = 0; wait_n(4);
        addr = 17'h1_0C0C; dq_in = 16'hC0DE; wait_n(4);
        ce_n = 1; wait_n(4);
        dq_in = 16'hDEAD; wait_n(4);
        we_n = 1; wait_n(4);
        chk("R5 one strobe second write", n_strobe, 2);
        chk("R4 addr at later fall (we)", {15'd0, wr_addr}, 32'h1_0B0B);
        chk("R5 data at first rise (ce)", {16'd0, wr_data}, 32'h0000_C0DE);

        // R5: oe low blocks a write cycle
        dq_in = 16'h7777; addr = 17'h0_0444; ce_n = 0; oe_n = 0; we_n = 0; wait_n(4);
        ce_n = 1; oe_n = 1; we_n = 1; wait_n(4);
        chk("R5 no write with oe low", n_strobe, 2);
        chk("R5 wr_data untouched", {16'd0, wr_data}, 32'h0000_C0DE);

        // R6/R7/R9: identification sweep, both entries and both widths
        for (int m = 0; m < 2; m++) begin
            for (int w = 0; w < 2; w++) begin
                for (int lo2 = 0; lo2 < 4; lo2++) begin
                    for (int k = 0; k < 4; k++) begin
                        seed = next_rand(seed);
                        do_read(m == 0 ? "R6 hv ident" : "R6 cmd ident",
                                m == 0, m == 1, w[0],
                                {seed[20:6], lo2[1:0]});
                    end
                end
            end
        end

        // R8: every block against a map and its inverse, both widths
        for (int p = 0; p < 2; p++) begin
            for (int b = 0; b < 32; b++) begin
                seed = next_rand(seed);
                do_read("R8 protect verify", 1'b1, seed[0], p[0],
                        {b[4:0], seed[11:7], 1'b0, seed[16:13], 2'b10});
            end
            prot_map = ~prot_map;
        end

        // R9: plain array reads
        for (int k = 0; k < 8; k++) begin
            seed = next_rand(seed);
            do_read("R9 array", 1'b0, 1'b0, k[0], seed[22:6]);
        end

        // R10: inactivity window measured on both sides
        do_read("R10 setup", 1'b0, 1'b0, 1'b1, 17'h0_5555);
        addr = 17'h0_5AAA;
        wait_n(IDLE + 1);
        chk("R10 flag not yet up", {31'd0, low_power}, 32'd0);
        wait_n(3);
        chk("R10 flag up after idle", {31'd0, low_power}, 32'd1);
        chk("R10 still driving", {30'd0, dq_oe_hi, dq_oe_lo}, 32'd3);
        addr = 17'h0_5AAB;
        wait_n(4);
        chk("R10 flag cleared", {31'd0, low_power}, 32'd0);

        ce_n = 1; oe_n = 1; wait_n(4);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule